// File: doc/BRIEF.md
# Multiplexed Converter Serial-Port Slave

This block is the digital control side of a four-channel, 10-bit sampling converter that talks to a host over a framed serial port. The host frames a transfer with an active-low chip select. While the frame is open, the host drives a serial clock and a serial data input. All three lines are brought into a faster system clock domain through two-flop synchronizers, and their edges are detected there. The system clock must run at least eight times faster than the serial clock.

Inside a frame, the block counts 16-clock conversion slots. A frame may carry any number of slots back to back. Each slot moves through three phases: track, hold/convert, and power-down between slots.

During a slot, the host shifts in an 8-bit control word whose address field chooses the channel for the following slot. At the moment hold begins, the block latches the selected channel's 10-bit value from its parallel input ports, which stand in for the analog inputs. It then returns that value MSB first on the serial output, with a separate output-enable for the tri-state driver.

Top module: `adc_sport_slave`

## Requirements
- R1: While reset is applied, and while chip select is high after reset, `sdo_oe_o` is 0, `sdo_o` is 0, `pwrdn_o` is 1, and `track_o` and `hold_o` are 0.
- R2: If the serial clock is low when chip select falls, that chip-select fall is treated as the first falling clock edge and `track_o` rises. If the serial clock is high, `pwrdn_o` stays 1 until the first real falling clock edge, which starts track.
- R3: Within a slot, falling edges are numbered 1 to 16. Falls 1 to 3 give track. Falls 4 to 15 give hold. Fall 16 gives power-down, which lasts until fall 1 of the next slot. Exactly one of the three phase outputs is 1 at any time.
- R4: The data input is captured on the first 8 rising clock edges of each slot, MSB first, as control word bits 7 down to 0. Bits 4:3 select the channel (00 selects port 0, 01 port 1, 10 port 2, 11 port 3). Bits 7:5 and 2:0 have no effect on any output.
- R5: The channel named in a slot's control word is the one converted in the next slot. The first conversion after reset uses port 0.
- R6: The output is 0 after falls 1 to 3 and after falls 14 to 16. After fall n, for n from 4 to 13, it carries result bit 13-n, which is bit 9 (the MSB) first down to bit 0.
- R7: The selected port value is latched at fall 4. Changing the input ports after that fall does not alter the bits that follow in the same slot.
- R8: In a frame with several slots, the edge counting restarts every 16 falls. The last committed channel address is kept across chip-select high periods.
- R9: Whenever chip select is high, `sdo_oe_o` is 0, `sdo_o` is 0 and `pwrdn_o` is 1. Raising chip select in the middle of a slot abandons that slot.
- R10: A control word is committed only on the slot's 8th rising edge. If a frame ends before that edge, the previously committed channel stays selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low chip select, frames a transfer |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial control-word input |
| sample_i | input | 40 | Four 10-bit channel values; port k at bits 10k+9:10k |
| sdo_o | output | 1 | Serial result output |
| sdo_oe_o | output | 1 | Output enable for the external tri-state driver |
| track_o | output | 1 | Track phase indicator |
| hold_o | output | 1 | Hold/convert phase indicator |
| pwrdn_o | output | 1 | Power-down indicator |

## Verification
Two things can happen in the same system-clock cycle: the opening of a frame and the first falling clock edge, because a chip-select fall with the serial clock low must also count as fall 1. The bench opens one frame with the serial clock parked low and another with it parked high. In the low case it expects `track_o` within the first bit time and the converted data aligned to falls 4 to 13. In the high case it expects power-down until the first real falling edge. The bench also runs a long multi-slot frame in which each slot commits an address while the previous address is being converted, and it checks that the converted channel follows the one-slot delay.

// File: rtl/adc_sport_pkg.sv
package adc_sport_pkg;

    // Operating phase of the converter within a slot
    typedef enum logic [1:0] {
        PH_PDN   = 2'd0,
        PH_TRACK = 2'd1,
        PH_HOLD  = 2'd2
    } phase_e;

endpackage

// File: rtl/adc_sport_sync.sv
// Two-flop synchronizer bank; the low N_EDGE bits get a third stage so the
// caller can detect edges on them.
module adc_sport_sync #(
    parameter int           N       = 3,
    parameter int           N_EDGE  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      async_i,
    output logic [N-1:0]      lvl_o,
    output logic [N_EDGE-1:0] prv_o
);

    typedef struct packed {
        logic [N-1:0]      s1;
        logic [N-1:0]      s2;
        logic [N_EDGE-1:0] s3;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = async_i;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2[N_EDGE-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q.s1 <= RST_VAL;
            sy_q.s2 <= RST_VAL;
            sy_q.s3 <= RST_VAL[N_EDGE-1:0];
        end else begin
            sy_q <= sy_d;
        end
    end

    assign lvl_o = sy_q.s2;
    assign prv_o = sy_q.s3;

endmodule

// File: rtl/adc_sport_seq.sv
// Slot sequencer: numbers clock edges within a slot, decodes the phase,
// gathers the address bits of the control word and commits them.
module adc_sport_seq
    import adc_sport_pkg::*;
#(
    parameter int SLOT_CLKS  = 16,
    parameter int TRACK_CLKS = 3,
    parameter int DATA_W     = 10,
    parameter int CTRL_W     = 8,
    parameter int ADDR_LSB   = 3,
    parameter int CH_W       = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_lvl_i,
    input  logic            cs_prv_i,
    input  logic            sclk_lvl_i,
    input  logic            sclk_prv_i,
    input  logic            din_i,
    output phase_e          phase_o,
    output logic            load_o,
    output logic            shift_o,
    output logic            dout_en_o,
    output logic [CH_W-1:0] sel_o
);

    localparam int CNT_W = $clog2(SLOT_CLKS + 1);
    localparam logic [CNT_W-1:0] SLOT_LAST  = CNT_W'(SLOT_CLKS);
    localparam logic [CNT_W-1:0] TRACK_LAST = CNT_W'(TRACK_CLKS);
    localparam logic [CNT_W-1:0] HOLD_EDGE  = CNT_W'(TRACK_CLKS + 1);
    localparam logic [CNT_W-1:0] LAST_EDGE  = CNT_W'(TRACK_CLKS + DATA_W);
    localparam logic [CNT_W-1:0] CTRL_LAST  = CNT_W'(CTRL_W);

    typedef struct packed {
        logic [CNT_W-1:0] fcnt;   // falling edges seen in this slot
        logic [CNT_W-1:0] rcnt;   // rising edges seen in this slot
        logic [CH_W-1:0]  pend;   // address bits gathered so far
        logic [CH_W-1:0]  addr;   // committed address for next load
    } seq_t;

    seq_t sq_d, sq_q;

    logic             active;
    logic             cs_fall;
    logic             fall_ev;
    logic             rise_ev;
    logic [CNT_W-1:0] fbase;
    logic [CNT_W-1:0] rbase;
    int               bitpos;

    always_comb begin
        active  = !cs_lvl_i;
        cs_fall = cs_prv_i && !cs_lvl_i;
        // A chip-select fall with the clock low stands in for the first fall
        fall_ev = active && ((sclk_prv_i && !sclk_lvl_i) || (cs_fall && !sclk_lvl_i));
        rise_ev = active && !sclk_prv_i && sclk_lvl_i;
        fbase   = cs_fall ? '0 : sq_q.fcnt;
        rbase   = cs_fall ? '0 : sq_q.rcnt;
        bitpos  = 0;

        sq_d = sq_q;
        if (!active) begin
            sq_d.fcnt = '0;
            sq_d.rcnt = '0;
        end else begin
            sq_d.fcnt = fbase;
            sq_d.rcnt = rbase;
            if (fall_ev) begin
                if (fbase == '0 || fbase == SLOT_LAST) begin
                    sq_d.fcnt = CNT_W'(1);
                end else begin
                    sq_d.fcnt = fbase + CNT_W'(1);
                end
            end
            if (rise_ev) begin
                sq_d.rcnt = (rbase == SLOT_LAST) ? CNT_W'(1) : rbase + CNT_W'(1);
                bitpos    = CTRL_W - int'(sq_d.rcnt);
                for (int b = 0; b < CH_W; b++) begin
                    if (bitpos == ADDR_LSB + b) begin
                        sq_d.pend[b] = din_i;
                    end
                end
                if (sq_d.rcnt == CTRL_LAST) begin
                    sq_d.addr = sq_d.pend;
                end
            end
        end

        load_o  = fall_ev && (sq_d.fcnt == HOLD_EDGE);
        shift_o = fall_ev && (sq_d.fcnt > HOLD_EDGE) && (sq_d.fcnt <= LAST_EDGE);

        if (!active || sq_q.fcnt == '0 || sq_q.fcnt == SLOT_LAST) begin
            phase_o = PH_PDN;
        end else if (sq_q.fcnt <= TRACK_LAST) begin
            phase_o = PH_TRACK;
        end else begin
            phase_o = PH_HOLD;
        end

        dout_en_o = active && (sq_q.fcnt >= HOLD_EDGE) && (sq_q.fcnt <= LAST_EDGE);
        sel_o     = sq_q.addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

endmodule

// File: rtl/adc_sport_shift.sv
// Result register: captures the selected channel at hold entry and
// presents it MSB first, one bit per falling serial-clock edge.
module adc_sport_shift #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 10,
    parameter int CH_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*DATA_W-1:0] sample_i,
    input  logic [CH_W-1:0]          sel_i,
    input  logic                     load_i,
    input  logic                     shift_i,
    output logic                     msb_o
);

    logic [DATA_W-1:0] chan [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign chan[g] = sample_i[g*DATA_W +: DATA_W];
    end

    typedef struct packed {
        logic [DATA_W-1:0] sh;
    } shr_t;

    shr_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i) begin
            sr_d.sh = chan[sel_i];
        end else if (shift_i) begin
            sr_d.sh = {sr_q.sh[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign msb_o = sr_q.sh[DATA_W-1];

endmodule

// File: rtl/adc_sport_slave.sv
module adc_sport_slave
    import adc_sport_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int DATA_W     = 10,
    parameter int SLOT_CLKS  = 16,
    parameter int TRACK_CLKS = 3,
    parameter int CTRL_W     = 8,
    parameter int ADDR_LSB   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n_i,
    input  logic                     sclk_i,
    input  logic                     sdi_i,
    input  logic [NUM_CH*DATA_W-1:0] sample_i,
    output logic                     sdo_o,
    output logic                     sdo_oe_o,
    output logic                     track_o,
    output logic                     hold_o,
    output logic                     pwrdn_o
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    // Synchronized bit order: {data-in, serial clock, chip select}
    logic [2:0]      lvl;
    logic [1:0]      prv;
    phase_e          phase;
    logic            load;
    logic            shift;
    logic            dout_en;
    logic [CH_W-1:0] sel;
    logic            msb;

    adc_sport_sync #(
        .N       (3),
        .N_EDGE  (2),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi_i, sclk_i, cs_n_i}),
        .lvl_o   (lvl),
        .prv_o   (prv)
    );

    adc_sport_seq #(
        .SLOT_CLKS  (SLOT_CLKS),
        .TRACK_CLKS (TRACK_CLKS),
        .DATA_W     (DATA_W),
        .CTRL_W     (CTRL_W),
        .ADDR_LSB   (ADDR_LSB),
        .CH_W       (CH_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_lvl_i   (lvl[0]),
        .cs_prv_i   (prv[0]),
        .sclk_lvl_i (lvl[1]),
        .sclk_prv_i (prv[1]),
        .din_i      (lvl[2]),
        .phase_o    (phase),
        .load_o     (load),
        .shift_o    (shift),
        .dout_en_o  (dout_en),
        .sel_o      (sel)
    );

    adc_sport_shift #(
        .NUM_CH   (NUM_CH),
        .DATA_W   (DATA_W),
        .CH_W     (CH_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_i),
        .sel_i    (sel),
        .load_i   (load),
        .shift_i  (shift),
        .msb_o    (msb)
    );

    always_comb begin
        sdo_oe_o = !lvl[0];
        sdo_o    = sdo_oe_o && dout_en && msb;
        track_o  = (phase == PH_TRACK);
        hold_o   = (phase == PH_HOLD);
        pwrdn_o  = (phase == PH_PDN);
    end

endmodule

// File: rtl/adc_sport_slave_chk.sv
module adc_sport_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sdo_o,
    input logic sdo_oe_o,
    input logic track_o,
    input logic hold_o,
    input logic pwrdn_o
);

    assert_one_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({track_o, hold_o, pwrdn_o}) == 1);

    assert_hold_from_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $past(track_o));

    assert_track_from_pdn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(track_o) |-> $past(pwrdn_o));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe_o |-> (!sdo_o && pwrdn_o));

    assert_track_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        track_o |-> !sdo_o);

endmodule

bind adc_sport_slave adc_sport_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o),
    .track_o  (track_o),
    .hold_o   (hold_o),
    .pwrdn_o  (pwrdn_o)
);

// File: tb/adc_sport_slave_tb.sv
module adc_sport_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;   // system clocks per serial half-period
    localparam int NVEC       = 6;

    // Each vector: {control word [9:2], channel expected in this slot [1:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        {8'h08, 2'd0},   // first slot after reset converts port 0; asks for port 1
        {8'hFF, 2'd1},   // asks for port 3, ignored bits all ones
        {8'hE7, 2'd3},   // field 00 with every ignored bit set
        {8'h10, 2'd0},   // asks for port 2
        {8'h08, 2'd2},   // asks for port 1
        {8'h38, 2'd1}    // field 11 with bit 5 set
    };

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n  = 1'b1;
    logic       sclk  = 1'b1;
    logic       sdi   = 1'b0;
    logic [9:0] samp [4];
    logic [39:0] sample_flat;
    logic       sdo, sdo_oe, track, hold, pwrdn;

    int checks   = 0;
    int failures = 0;

    assign sample_flat = {samp[3], samp[2], samp[1], samp[0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_sport_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_i   (cs_n),
        .sclk_i   (sclk),
        .sdi_i    (sdi),
        .sample_i (sample_flat),
        .sdo_o    (sdo),
        .sdo_oe_o (sdo_oe),
        .track_o  (track),
        .hold_o   (hold),
        .pwrdn_o  (pwrdn)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One 16-clock slot. cs_first: the chip-select fall was fall 1.
    task automatic run_slot(input logic [7:0] ctrl, input logic cs_first,
                            input logic poke, output logic [9:0] got,
                            output int pad_bad, output int ph_bad);
        logic [2:0] ph_exp;
        got     = '0;
        pad_bad = 0;
        ph_bad  = 0;
        for (int n = 1; n <= 16; n++) begin
            if (!(n == 1 && cs_first)) sclk = 1'b0;
            sdi = (n <= 8) ? ctrl[8-n] : 1'b0;
            wait_clk(HALF);
            if (n >= 4 && n <= 13) got[13-n] = sdo;
            else if (sdo !== 1'b0) pad_bad++;
            if (n <= 3)       ph_exp = 3'b100;
            else if (n <= 15) ph_exp = 3'b010;
            else              ph_exp = 3'b001;
            if ({track, hold, pwrdn} !== ph_exp) ph_bad++;
            if (poke && n == 5) begin
                for (int c = 0; c < 4; c++) samp[c] = ~samp[c];
            end
            sclk = 1'b1;
            wait_clk(HALF);
        end
        if (poke) begin
            for (int c = 0; c < 4; c++) samp[c] = ~samp[c];
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [9:0] got;
        logic [9:0] exp_v;
        int pad_bad, ph_bad;

        samp[0] = 10'h2A5;
        samp[1] = 10'h15A;
        samp[2] = 10'h3FF;
        samp[3] = 10'h001;

        // R1: reset state
        wait_clk(5);
        check("R1", "outputs in reset", {27'd0, sdo_oe, sdo, track, hold, pwrdn}, 32'h1);
        rst_n = 1'b1;
        wait_clk(6);
        check("R1", "idle after reset", {27'd0, sdo_oe, sdo, track, hold, pwrdn}, 32'h1);

        // Frame A: clock parked high, several slots back to back
        cs_n = 1'b0;
        wait_clk(HALF);
        check("R2", "clock high: no track before first fall", {30'd0, track, pwrdn}, 32'h1);
        check("R9", "enable while selected", {31'd0, sdo_oe}, 32'h1);
        for (int v = 0; v < NVEC; v++) begin
            exp_v = samp[VEC[v][1:0]];
            run_slot(VEC[v][9:2], 1'b0, 1'b0, got, pad_bad, ph_bad);
            check("R4_R5", $sformatf("slot %0d result", v), {22'd0, got}, {22'd0, exp_v});
            check("R6", $sformatf("slot %0d pad bits", v), pad_bad, 0);
            check("R3_R8", $sformatf("slot %0d phases", v), ph_bad, 0);
        end
        cs_n = 1'b1;
        wait_clk(HALF);
        check("R9", "deselected after frame", {29'd0, sdo_oe, sdo, pwrdn}, 32'h1);

        // Frame B: clock parked low, chip-select fall is fall 1; inputs
        // change after hold entry; address from frame A persists (port 3)
        sclk = 1'b0;
        wait_clk(HALF);
        cs_n = 1'b0;
        exp_v = samp[3];
        run_slot(8'h10, 1'b1, 1'b1, got, pad_bad, ph_bad);
        check("R2", "clock low: phases with select as first fall", ph_bad, 0);
        check("R7_R8", "latched result of port 3", {22'd0, got}, {22'd0, exp_v});
        check("R6", "pad bits, clock-low frame", pad_bad, 0);
        cs_n = 1'b1;
        wait_clk(HALF);

        // Frame C: aborted after 6 clocks, word would select port 1
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int n = 1; n <= 6; n++) begin
            sclk = 1'b0;
            sdi  = (8'h08 >> (8 - n)) & 8'h01;
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
        end
        check("R9", "hold while mid-slot", {31'd0, hold}, 32'h1);
        cs_n = 1'b1;
        wait_clk(HALF);
        check("R9", "abort returns to power-down", {28'd0, sdo_oe, sdo, hold, pwrdn}, 32'h1);

        // Frame D: port 2 from frame B must still be selected
        cs_n = 1'b0;
        wait_clk(HALF);
        exp_v = samp[2];
        run_slot(8'h00, 1'b0, 1'b0, got, pad_bad, ph_bad);
        check("R10", "cut-short word not committed", {22'd0, got}, {22'd0, exp_v});
        check("R3", "phases after abort", ph_bad, 0);
        cs_n = 1'b1;
        wait_clk(HALF);
        check("R1", "idle at end", {27'd0, sdo_oe, sdo, track, hold, pwrdn}, 32'h1);

        summary();
        $finish;
    end

endmodule